// File: doc/BRIEF.md
# Link Interface Power Sequencer

This block sits on the physical-layer side of the parallel interface between a serial-bus PHY and its link-layer controller. It runs from the free-running reference clock and watches the link's power-status input. That input may be held as a steady level or sent as a pulse train through an isolation barrier, and any high sample counts as activity. A short stretch of inactivity takes the interface to reset. A long stretch takes it on to disabled, where the link clock is stopped. When activity returns, the block restarts the link clock and plays a fixed start-up pattern on the control and data lines before it hands them back to the normal packet path.

While the interface is down, the block holds the control and data lines at zero and blocks incoming link requests. It also drops any status the PHY produces and pulses a cancel strobe, so that pending bus and register-read requests in the neighbouring logic are flushed. A low-power indication is raised when the interface is disabled and no bus port is active. That indication also selects the long clock-restart delay the next time activity returns.

Top module: `phy_link_pwr_ctrl`

## Requirements
- R1: The power-status input passes through a two-stage synchronizer. From an operational state, once the synchronized input has been low for more than RST_CYC consecutive cycles, the interface enters reset. In reset the link clock enable stays high.
- R2: If the synchronized input stays low for more than DIS_CYC consecutive cycles, the interface moves from reset to disabled and the link clock enable goes low.
- R3: In reset and in disabled, ctl_o is 00 and d_o is all zeros, and lreq_o stays low whatever lreq_i does.
- R4: stat_o is low in every state other than normal, so status produced while the interface is down is dropped. cancel_o is high for exactly the first cycle of reset when reset is entered from initialization or normal operation.
- R5: Every high sample of the synchronized input restarts the inactivity count. A pulse train with low stretches shorter than RST_CYC cycles therefore keeps the interface operational.
- R6: After the asynchronous reset rst_ni, the interface is in the disabled state with the link clock enable low.
- R7: From disabled, a high synchronized input starts a clock-restart wait. The link clock enable rises after WAKE_FAST_CYC cycles, or after WAKE_LP_CYC cycles if low_power_o was high when the wait began.
- R8: Initialization drives ZERO_CYC cycles (default 7) of ctl_o=00 with d_o=0. It then drives RX_CYC cycles of ctl_o=10 (receive) with d_o all ones, then one cycle of ctl_o=00 (idle) with d_o=0, and then enters normal operation. Link requests are accepted from that idle cycle on.
- R9: low_power_o is high exactly when the interface is disabled and port_active_i is low.
- R10: In reset, a high synchronized input starts initialization at once, without a clock-restart wait, and the link clock enable stays high throughout.
- R11: In normal operation ctl_o and d_o follow ctl_i and d_i, lreq_o follows lreq_i, and stat_o follows stat_i. Control encodings are 00 idle, 01 status, 10 receive and 11 grant.
- R12: If the synchronized input has been low for more than RST_CYC cycles during the clock-restart wait, the block returns to disabled without enabling the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| lps_i | input | 1 | Link power-status, level or pulsed, asynchronous |
| port_active_i | input | 1 | At least one bus port is active |
| lreq_i | input | 1 | Request line from the link |
| stat_i | input | 1 | Status-valid strobe from the PHY core |
| ctl_i | input | 2 | Control code from the packet path |
| d_i | input | DW | Data from the packet path |
| lclk_en_o | output | 1 | Link clock enable |
| ctl_o | output | 2 | Control lines toward the link |
| d_o | output | DW | Data lines toward the link |
| lreq_o | output | 1 | Link request accepted into the PHY |
| stat_o | output | 1 | Status forwarded for transfer |
| cancel_o | output | 1 | One-cycle flush of pending bus and register-read requests |
| low_power_o | output | 1 | PHY may enter its low-power state |

## Verification
The hardest path to reach is a pulsed power-status input whose low stretches sit just under or just over the reset window. There the synchronizer latency decides whether reset is entered at all. The bench sweeps pulse trains with low times on both sides of that window, and the reference model tracks the synchronizer delay cycle by cycle. A second hard corner is a collapse of activity during the long clock-restart wait or partway through initialization. The random phase reaches it by mixing short high bursts with long low stretches while port_active_i toggles, so that both restart delays are exercised.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_DIS  = 3'd0,
    ST_WAKE = 3'd1,
    ST_INIT = 3'd2,
    ST_NORM = 3'd3,
    ST_RST  = 3'd4
  } lpc_state_e;

  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_RX   = 2'b10;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpc_idle_timer.sv
module lpc_idle_timer #(
  parameter int RST_CYC = 128,
  parameter int DIS_CYC = 1280
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic rst_hit_o,
  output logic dis_hit_o
);
  localparam int IW = $clog2(DIS_CYC + 1);
  localparam logic [IW-1:0] RST_LIM = IW'(RST_CYC);
  localparam logic [IW-1:0] DIS_LIM = IW'(DIS_CYC);

  logic [IW-1:0] cnt_q;

  // saturating count of low cycles; any high sample restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (act_i)            cnt_q <= '0;
    else if (cnt_q < DIS_LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign rst_hit_o = (cnt_q >= RST_LIM);
  assign dis_hit_o = (cnt_q >= DIS_LIM);
endmodule

// File: rtl/lpc_phase_cnt.sv
module lpc_phase_cnt #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [PW-1:0] cnt_o,
  output logic          zero_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lpc_out_mux.sv
module lpc_out_mux
  import lpc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PW       = 8,
  parameter int ZERO_CYC = 7,
  parameter int RX_CYC   = 1
) (
  input  lpc_state_e    st_i,
  input  logic [PW-1:0] ph_i,
  input  logic [1:0]    ctl_i,
  input  logic [DW-1:0] d_i,
  input  logic          lreq_i,
  input  logic          stat_i,
  output logic          lclk_en_o,
  output logic [1:0]    ctl_o,
  output logic [DW-1:0] d_o,
  output logic          lreq_o,
  output logic          stat_o
);
  localparam logic [PW-1:0] RX_START = PW'(ZERO_CYC);
  localparam logic [PW-1:0] IDLE_PH  = PW'(ZERO_CYC + RX_CYC);

  logic accept;

  always_comb begin
    ctl_o = CTL_IDLE;
    d_o   = '0;
    unique case (st_i)
      ST_NORM: begin
        ctl_o = ctl_i;
        d_o   = d_i;
      end
      ST_INIT: begin
        if (ph_i >= RX_START && ph_i < IDLE_PH) begin
          ctl_o = CTL_RX;
          d_o   = '1;
        end
      end
      default: ;
    endcase
  end

  assign lclk_en_o = (st_i == ST_INIT) || (st_i == ST_NORM) || (st_i == ST_RST);
  assign accept    = (st_i == ST_NORM) || ((st_i == ST_INIT) && (ph_i == IDLE_PH));
  assign lreq_o    = lreq_i & accept;
  assign stat_o    = stat_i & (st_i == ST_NORM);
endmodule

// File: rtl/phy_link_pwr_ctrl.sv
module phy_link_pwr_ctrl
  import lpc_pkg::*;
#(
  parameter int DW            = 8,
  parameter int RST_CYC       = 128,
  parameter int DIS_CYC       = 1280,
  parameter int WAKE_FAST_CYC = 2,
  parameter int WAKE_LP_CYC   = 262144,
  parameter int ZERO_CYC      = 7,
  parameter int RX_CYC        = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lps_i,
  input  logic          port_active_i,
  input  logic          lreq_i,
  input  logic          stat_i,
  input  logic [1:0]    ctl_i,
  input  logic [DW-1:0] d_i,
  output logic          lclk_en_o,
  output logic [1:0]    ctl_o,
  output logic [DW-1:0] d_o,
  output logic          lreq_o,
  output logic          stat_o,
  output logic          cancel_o,
  output logic          low_power_o
);
  localparam int INIT_LAST = ZERO_CYC + RX_CYC;
  localparam int PMAX      = (WAKE_LP_CYC > INIT_LAST) ? WAKE_LP_CYC : INIT_LAST + 1;
  localparam int PW        = $clog2(PMAX + 1);
  localparam logic [PW-1:0] LAST_PH  = PW'(INIT_LAST);
  localparam logic [PW-1:0] WAKE_LP  = PW'(WAKE_LP_CYC - 1);
  localparam logic [PW-1:0] WAKE_FST = PW'(WAKE_FAST_CYC - 1);

  lpc_state_e    st_q, st_d;
  logic          lps_s, rst_hit, dis_hit;
  logic          ph_clr, ph_load, ph_inc, ph_dec, ph_zero;
  logic [PW-1:0] ph;
  logic          cancel_q;

  lpc_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lps_i),
    .q_o   (lps_s)
  );

  lpc_idle_timer #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (lps_s),
    .rst_hit_o(rst_hit),
    .dis_hit_o(dis_hit)
  );

  lpc_phase_cnt #(.PW(PW)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ph_clr),
    .load_i    (ph_load),
    .load_val_i(low_power_o ? WAKE_LP : WAKE_FST),
    .inc_i     (ph_inc),
    .dec_i     (ph_dec),
    .cnt_o     (ph),
    .zero_o    (ph_zero)
  );

  always_comb begin
    st_d    = st_q;
    ph_clr  = 1'b0;
    ph_load = 1'b0;
    ph_inc  = 1'b0;
    ph_dec  = 1'b0;
    unique case (st_q)
      ST_DIS: if (lps_s) begin
        st_d    = ST_WAKE;
        ph_load = 1'b1;
      end
      ST_WAKE: begin
        if (rst_hit) st_d = ST_DIS;
        else if (ph_zero) begin
          st_d   = ST_INIT;
          ph_clr = 1'b1;
        end else ph_dec = 1'b1;
      end
      ST_INIT: begin
        if (rst_hit)             st_d = ST_RST;
        else if (ph == LAST_PH)  st_d = ST_NORM;
        else                     ph_inc = 1'b1;
      end
      ST_NORM: if (rst_hit) st_d = ST_RST;
      ST_RST: begin
        if (dis_hit) st_d = ST_DIS;
        else if (lps_s) begin
          st_d   = ST_INIT;
          ph_clr = 1'b1;
        end
      end
      default: st_d = ST_DIS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_DIS;
      cancel_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cancel_q <= ((st_q == ST_INIT) || (st_q == ST_NORM)) && (st_d == ST_RST);
    end
  end

  lpc_out_mux #(.DW(DW), .PW(PW), .ZERO_CYC(ZERO_CYC), .RX_CYC(RX_CYC)) u_mux (
    .st_i     (st_q),
    .ph_i     (ph),
    .ctl_i    (ctl_i),
    .d_i      (d_i),
    .lreq_i   (lreq_i),
    .stat_i   (stat_i),
    .lclk_en_o(lclk_en_o),
    .ctl_o    (ctl_o),
    .d_o      (d_o),
    .lreq_o   (lreq_o),
    .stat_o   (stat_o)
  );

  assign cancel_o    = cancel_q;
  assign low_power_o = (st_q == ST_DIS) && !port_active_i;
endmodule

// File: rtl/lpc_chk.sv
module lpc_chk
  import lpc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input lpc_state_e    st_i,
  input logic          lps_s_i,
  input logic          lclk_en_i,
  input logic [1:0]    ctl_i,
  input logic [DW-1:0] d_i,
  input logic          lreq_i,
  input logic          stat_i,
  input logic          cancel_i,
  input logic          low_power_i
);
  AST_DOWN_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RST || st_i == ST_DIS) |-> (ctl_i == 2'b00 && d_i == '0 && !lreq_i)); // R3

  AST_STAT_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_NORM) |-> !stat_i); // R4

  AST_CANCEL_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |-> (st_i == ST_RST && ($past(st_i) == ST_INIT || $past(st_i) == ST_NORM))); // R4

  AST_DIS_CLK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DIS) |-> !lclk_en_i); // R2

  AST_LP_ONLY_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_i |-> (st_i == ST_DIS)); // R9

  AST_RST_REINIT_ON_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_INIT && $past(st_i) == ST_RST) |-> ($past(lps_s_i) && $past(lclk_en_i))); // R10

  AST_RX_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == 2'b10 && $past(ctl_i) != 2'b10 && st_i == ST_INIT) |-> ($past(ctl_i) == 2'b00 && $past(d_i) == '0)); // R8
endmodule

bind phy_link_pwr_ctrl lpc_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .st_i       (st_q),
  .lps_s_i    (lps_s),
  .lclk_en_i  (lclk_en_o),
  .ctl_i      (ctl_o),
  .d_i        (d_o),
  .lreq_i     (lreq_o),
  .stat_i     (stat_o),
  .cancel_i   (cancel_o),
  .low_power_i(low_power_o)
);

// File: tb/phy_link_pwr_ctrl_tb.sv
module phy_link_pwr_ctrl_tb;
  localparam int DW = 8;
  localparam int RST = 16;
  localparam int DIS = 80;
  localparam int WF = 2;
  localparam int WL = 40;
  localparam int ZC = 7;
  localparam int RX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lps = 1'b0, pact = 1'b0, lreq = 1'b0, stat = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic [DW-1:0] d = '0;
  logic en_o, lreq_o, stat_o, cancel_o, lp_o;
  logic [1:0] ctl_o;
  logic [DW-1:0] d_o;

  int checks = 0, errors = 0, cancel_seen = 0;
  bit rnd_en = 1'b1, done = 1'b0;

  always #10 clk = ~clk;

  phy_link_pwr_ctrl #(.DW(DW), .RST_CYC(RST), .DIS_CYC(DIS), .WAKE_FAST_CYC(WF),
                      .WAKE_LP_CYC(WL), .ZERO_CYC(ZC), .RX_CYC(RX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lps_i(lps), .port_active_i(pact), .lreq_i(lreq),
    .stat_i(stat), .ctl_i(ctl), .d_i(d), .lclk_en_o(en_o), .ctl_o(ctl_o), .d_o(d_o),
    .lreq_o(lreq_o), .stat_o(stat_o), .cancel_o(cancel_o), .low_power_o(lp_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 dis, 1 wake, 2 init, 3 normal, 4 reset
  int m_s1, m_s2, m_idle, m_st, m_ph, m_cancel;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_idle = 0; m_st = 0; m_ph = 0; m_cancel = 0;
    end else begin
      int nst, nph;
      bit rh, dh;
      rh = (m_idle >= RST); dh = (m_idle >= DIS);
      nst = m_st; nph = m_ph;
      case (m_st)
        0: if (m_s2 != 0) begin nst = 1; nph = (pact ? WF : WL) - 1; end
        1: if (rh) nst = 0; else if (m_ph == 0) begin nst = 2; nph = 0; end else nph = m_ph - 1;
        2: if (rh) nst = 4; else if (m_ph == ZC + RX) nst = 3; else nph = m_ph + 1;
        3: if (rh) nst = 4;
        default: if (dh) nst = 0; else if (m_s2 != 0) begin nst = 2; nph = 0; end
      endcase
      m_cancel = ((m_st == 2 || m_st == 3) && nst == 4) ? 1 : 0;
      if (m_s2 != 0) m_idle = 0; else if (m_idle < DIS) m_idle = m_idle + 1;
      m_s2 = m_s1; m_s1 = int'(lps);
      m_st = nst; m_ph = nph;
    end
  end

  // random packet-path traffic
  always @(negedge clk) begin
    if (rnd_en) begin
      ctl  <= 2'($urandom);
      d    <= DW'($urandom);
      lreq <= 1'($urandom);
      stat <= 1'($urandom);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int e_ctl, e_d;
      bit e_en, acc;
      string tag;
      e_en = (m_st == 2 || m_st == 3 || m_st == 4);
      e_ctl = 0; e_d = 0;
      if (m_st == 3) begin e_ctl = int'(ctl); e_d = int'(d); end
      else if (m_st == 2 && m_ph >= ZC && m_ph < ZC + RX) begin e_ctl = 2; e_d = 255; end
      acc = (m_st == 3) || (m_st == 2 && m_ph == ZC + RX);
      case (m_st)
        0: tag = "R2"; 1: tag = "R7"; 2: tag = "R8"; 3: tag = "R11"; default: tag = "R3";
      endcase
      chk(en_o == e_en, {tag, " clk_en"}, int'(en_o), int'(e_en));
      chk(int'(ctl_o) == e_ctl, {tag, " ctl"}, int'(ctl_o), e_ctl);
      chk(int'(d_o) == e_d, {tag, " data"}, int'(d_o), e_d);
      chk(lreq_o == (lreq & acc), {tag, " lreq"}, int'(lreq_o), int'(lreq & acc));
      chk(stat_o == (stat & (m_st == 3)), "R4 stat", int'(stat_o), int'(stat & (m_st == 3)));
      chk(int'(cancel_o) == m_cancel, "R4 cancel", int'(cancel_o), m_cancel);
      chk(lp_o == ((m_st == 0) && !pact), "R9 low_power", int'(lp_o), int'((m_st == 0) && !pact));
      if (cancel_o) cancel_seen++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_en(output int n);
    n = 0;
    do begin
      @(negedge clk); #3; n++;
    end while (!en_o && n < 1000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    cyc(3);
    rst_n = 1'b1;
    #3;
    chk(en_o == 1'b0, "R6 clk_en after reset", int'(en_o), 0);
    chk(lp_o == 1'b1, "R6 disabled low power", int'(lp_o), 1);
    cyc(5);

    // low-power wake
    @(negedge clk); lps = 1'b1;
    wait_en(n);
    chk(n == 3 + WL, "R7 low-power restart delay", n, 3 + WL);
    cyc(7); #3;
    chk(ctl_o == 2'b10 && d_o == 8'hFF, "R8 receive on 8th cycle", int'(ctl_o), 2);
    cyc(RX); #3;
    chk(ctl_o == 2'b00 && d_o == 8'h00, "R8 idle after receive", int'(ctl_o), 0);
    chk(lreq_o == lreq, "R8 requests accepted", int'(lreq_o), int'(lreq));
    cyc(20);

    // pulsed input keeps interface up
    n = cancel_seen;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); lps = 1'b0; cyc(RST - 4);
      @(negedge clk); lps = 1'b1; cyc(1);
    end
    #3;
    chk(cancel_seen == n && en_o, "R5 pulse train stays up", cancel_seen - n, 0);

    // reset entry
    @(negedge clk); lps = 1'b0;
    cyc(RST + 6); #3;
    chk(en_o == 1'b1 && ctl_o == 2'b00 && d_o == '0, "R1 reset keeps clock", int'(en_o), 1);
    chk(lreq_o == 1'b0, "R3 request ignored", int'(lreq_o), 0);
    chk(cancel_seen == n + 1, "R4 single cancel pulse", cancel_seen - n, 1);

    // reassert from reset
    @(negedge clk); lps = 1'b1;
    for (int i = 0; i < 3 + ZC; i++) begin
      @(negedge clk); #3;
      chk(en_o == 1'b1, "R10 clock held through restart", int'(en_o), 1);
    end
    chk(ctl_o == 2'b10, "R10 init starts without wait", int'(ctl_o), 2);
    cyc(20);

    // disable and fast wake
    @(negedge clk); lps = 1'b0;
    cyc(DIS + 10); #3;
    chk(en_o == 1'b0, "R2 clock stopped", int'(en_o), 0);
    pact = 1'b1; #1;
    chk(lp_o == 1'b0, "R9 port active blocks low power", int'(lp_o), 0);
    @(negedge clk); lps = 1'b1;
    wait_en(n);
    chk(n == 3 + WF, "R7 fast restart delay", n, 3 + WF);
    cyc(20);

    // wake abort
    @(negedge clk); lps = 1'b0;
    cyc(DIS + 10);
    pact = 1'b0;
    @(negedge clk); lps = 1'b1; cyc(3);
    @(negedge clk); lps = 1'b0;
    cyc(WL + 10); #3;
    chk(en_o == 1'b0, "R12 wake abort keeps clock off", int'(en_o), 0);

    // random power-status activity
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      lps = ~lps;
      pact = 1'($urandom);
      cyc(lps ? ($urandom % 6) : ($urandom % (DIS + 20)));
    end
    cyc(10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule